// File: doc/BRIEF.md
# Angle-to-Quadrature Incremental Encoder

This block turns an absolute angle, presented as a 12-bit word on every clock, into incremental quadrature signals A and B and a once-per-turn index Z. The block keeps an internal output position. Each time a spacing timer allows it, the block moves that position one quadrature state toward the angle. A downstream up/down counter that follows A and B therefore always sees legal single steps. When the angle moves faster than the programmed edge spacing allows, the outstanding steps are emitted back to back at that spacing until the position has caught up.

A deadband of 16 LSB separates the two directions of travel. While the position is rising it follows the angle exactly. It only starts to fall once the angle sits more than 16 LSB below it, and while falling it settles 16 LSB above the angle. An inversion bit mirrors the angle, so either sense of magnet rotation can be made to count upward. An 8-bit offset places the index anywhere on the turn in steps of 1/256 turn.

Two power-up behaviours are available. In the first, the outputs rest at all-high until the first valid angle arrives, and then jump straight to it. In the second, the outputs start at position zero and count upward, one step per spacing interval, until they reach the first reported angle, so the downstream counter learns the absolute position.

Top module: `abz_encoder`

## Requirements
- R1: Out of reset, with the hold start-up mode (start bit 0) the outputs are A=1, B=1, Z=1. With the counting start-up mode (start bit 1) they are A=0, B=0, Z=0, and they do not move before the first valid angle.
- R2: The output position p maps onto (A,B) by p mod 4: 0 gives 00, 1 gives 01, 2 gives 11, 3 gives 10. Each step changes p by exactly one, so at most one of A and B toggles per clock.
- R3: Let d be the target minus the position, taken modulo 4096 and read as a signed number. When d is between 1 and 2047, the position steps upward until it equals the target.
- R4: When d is below -16, the position steps downward until d equals -16. When d is between -16 and 0, the position holds.
- R5: The spacing field selects the minimum number of clocks between two edges, computed as ns × CLK_MHZ / 1000 (at least 1). Code 00 selects 500 ns, 01 selects 125 ns, 10 selects 8 µs and 11 selects 2 µs.
- R6: A jump of many steps is emitted as exactly that many edges, each the selected spacing after the previous one, until the position equals the target.
- R7: With the inversion bit at 1, the target is (4096 − angle) mod 4096. With it at 0, the target is the angle.
- R8: Z is 1 exactly when the position equals offset × 16 + 2, which is a state where A and B are both 1.
- R9: In hold start-up mode, A, B and Z stay at 1 until the first clock with the valid flag set. On the clock after that, the outputs show the target position directly.
- R10: In counting start-up mode, after the first valid flag the position counts only upward from zero until it equals the target, even when the target is more than half a turn away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| angle_i | input | ANGLE_W | Absolute angle, one LSB per quadrature state |
| angle_vld_i | input | 1 | Marks the angle as valid; its first assertion ends start-up |
| cfg_rev_i | input | 1 | Inverts the counting sense |
| cfg_spc_i | input | 2 | Minimum edge spacing code |
| cfg_count_start_i | input | 1 | 0: hold all-high until valid; 1: count up from zero |
| cfg_zoff_i | input | IDX_W | Index position in 1/256-turn steps |
| qa_o | output | 1 | Quadrature channel A |
| qb_o | output | 1 | Quadrature channel B |
| qz_o | output | 1 | Index pulse |

## Verification
The bench builds the block with CLK_MHZ = 8, so the four spacing codes come to 4, 1, 64 and 16 clocks. At those values every code can be timed edge to edge within a few thousand cycles, and a catch-up across most of a turn at one edge per clock fits the run. The bench follows A and B with its own up/down decoder, starting from zero in counting mode. This lets it compare absolute positions, edge counts, edge gaps and the index placement against values worked out from the deadband and wrap arithmetic.

// File: rtl/abz_pkg.sv
package abz_pkg;

  typedef enum logic [1:0] {
    SPC_500N = 2'b00,
    SPC_125N = 2'b01,
    SPC_8U   = 2'b10,
    SPC_2U   = 2'b11
  } spc_e;

  // Clock cycles covering a span of ns nanoseconds, never below one.
  function automatic int unsigned ns_to_cyc(input int unsigned ns,
                                            input int unsigned mhz);
    int unsigned c;
    c = (ns * mhz) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/abz_spacing_timer.sv
module abz_spacing_timer
  import abz_pkg::*;
#(
  parameter int unsigned CLK_MHZ = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel_i,
  input  logic       fire_i,
  output logic       ready_o
);

  localparam int unsigned C125  = ns_to_cyc(125, CLK_MHZ);
  localparam int unsigned C500  = ns_to_cyc(500, CLK_MHZ);
  localparam int unsigned C2000 = ns_to_cyc(2000, CLK_MHZ);
  localparam int unsigned C8000 = ns_to_cyc(8000, CLK_MHZ);
  localparam int unsigned CNT_W = $clog2(C8000 + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, span;
  logic             cnt_en;

  always_comb begin
    case (spc_e'(sel_i))
      SPC_125N: span = CNT_W'(C125);
      SPC_8U:   span = CNT_W'(C8000);
      SPC_2U:   span = CNT_W'(C2000);
      default:  span = CNT_W'(C500);
    endcase
  end

  // A step reloads the interval; otherwise the counter drains to zero.
  always_comb begin
    cnt_en = fire_i | (cnt_q != '0);
    cnt_d  = fire_i ? (span - 1'b1) : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ready_o = (cnt_q == '0);

endmodule

// File: rtl/abz_step_decide.sv
module abz_step_decide #(
  parameter int unsigned W    = 12,
  parameter int unsigned HYST = 16
) (
  input  logic [W-1:0] pos_i,
  input  logic [W-1:0] target_i,
  input  logic         catch_i,
  output logic         up_o,
  output logic         dn_o
);

  // Unsigned images of a signed difference below -HYST.
  localparam logic [W-1:0] DN_LIM = W'((1 << W) - HYST);

  logic [W-1:0] diff;

  always_comb begin
    diff = target_i - pos_i;
    if (catch_i) begin
      up_o = (diff != '0);
      dn_o = 1'b0;
    end else begin
      up_o = !diff[W-1] && (diff != '0);
      dn_o = diff[W-1] && (diff < DN_LIM);
    end
  end

endmodule

// File: rtl/abz_quad_out.sv
module abz_quad_out #(
  parameter int unsigned W    = 12,
  parameter int unsigned IW   = 8
) (
  input  logic [W-1:0]  pos_i,
  input  logic [IW-1:0] zoff_i,
  input  logic          hold_i,
  output logic          a_o,
  output logic          b_o,
  output logic          z_o
);

  localparam int unsigned LW = W - IW;

  logic [W-1:0] zpos;

  always_comb begin
    zpos = {zoff_i, LW'(2)};
    if (hold_i) begin
      a_o = 1'b1;
      b_o = 1'b1;
      z_o = 1'b1;
    end else begin
      a_o = pos_i[1];
      b_o = pos_i[1] ^ pos_i[0];
      z_o = (pos_i == zpos);
    end
  end

endmodule

// File: rtl/abz_encoder.sv
module abz_encoder
  import abz_pkg::*;
#(
  parameter int unsigned ANGLE_W = 12,
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned HYST    = 16,
  parameter int unsigned CLK_MHZ = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ANGLE_W-1:0] angle_i,
  input  logic               angle_vld_i,
  input  logic               cfg_rev_i,
  input  logic [1:0]         cfg_spc_i,
  input  logic               cfg_count_start_i,
  input  logic [IDX_W-1:0]   cfg_zoff_i,
  output logic               qa_o,
  output logic               qb_o,
  output logic               qz_o
);

  // Reset synchronizer: asserts at once, releases on a clock edge.
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic [ANGLE_W-1:0] pos_q, pos_d, target;
  logic               seen_q, seen_d, catch_q, catch_d;
  logic               pos_en, first, jump, fire, ready, step_up, step_dn, hold;

  assign target = cfg_rev_i ? ({ANGLE_W{1'b0}} - angle_i) : angle_i;

  abz_step_decide #(.W(ANGLE_W), .HYST(HYST)) u_decide (
    .pos_i    (pos_q),
    .target_i (target),
    .catch_i  (catch_q),
    .up_o     (step_up),
    .dn_o     (step_dn)
  );

  abz_spacing_timer #(.CLK_MHZ(CLK_MHZ)) u_timer (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .sel_i   (cfg_spc_i),
    .fire_i  (fire),
    .ready_o (ready)
  );

  always_comb begin
    first  = angle_vld_i & ~seen_q;
    jump   = first & ~cfg_count_start_i;
    fire   = seen_q & ready & (step_up | step_dn);
    pos_en = jump | fire;
    if (jump)         pos_d = target;
    else if (step_up) pos_d = pos_q + 1'b1;
    else              pos_d = pos_q - 1'b1;
    seen_d = seen_q | angle_vld_i;
    if (first & cfg_count_start_i)      catch_d = 1'b1;
    else if (catch_q && pos_q == target) catch_d = 1'b0;
    else                                 catch_d = catch_q;
    hold   = ~seen_q & ~cfg_count_start_i;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pos_q   <= '0;
      seen_q  <= 1'b0;
      catch_q <= 1'b0;
    end else begin
      if (pos_en) pos_q <= pos_d;
      seen_q  <= seen_d;
      catch_q <= catch_d;
    end
  end

  abz_quad_out #(.W(ANGLE_W), .IW(IDX_W)) u_out (
    .pos_i  (pos_q),
    .zoff_i (cfg_zoff_i),
    .hold_i (hold),
    .a_o    (qa_o),
    .b_o    (qb_o),
    .z_o    (qz_o)
  );

endmodule

// File: rtl/abz_encoder_chk.sv
module abz_encoder_chk
  import abz_pkg::*;
#(
  parameter int unsigned ANGLE_W = 12,
  parameter int unsigned CLK_MHZ = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ANGLE_W-1:0] pos,
  input logic               hold,
  input logic               catch_up,
  input logic [1:0]         spc,
  input logic               a,
  input logic               b,
  input logic               z
);

  logic [ANGLE_W-1:0] pos_r;
  logic               hold_r, had_chg;
  logic [15:0]        since;
  int unsigned        req;

  always_comb begin
    case (spc_e'(spc))
      SPC_125N: req = ns_to_cyc(125, CLK_MHZ);
      SPC_8U:   req = ns_to_cyc(8000, CLK_MHZ);
      SPC_2U:   req = ns_to_cyc(2000, CLK_MHZ);
      default:  req = ns_to_cyc(500, CLK_MHZ);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_r   <= '0;
      hold_r  <= 1'b1;
      had_chg <= 1'b0;
      since   <= '0;
    end else begin
      pos_r  <= pos;
      hold_r <= hold;
      if (pos != pos_r) begin
        since   <= 16'd1;
        had_chg <= !hold_r;
      end else if (since != 16'hFFFF) begin
        since <= since + 1'b1;
      end
    end
  end

  // R2
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(hold) && !hold) |-> ($countones({a, b} ^ $past({a, b})) <= 1));

  // R8
  z_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    z |-> (a && b));

  // R9
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (a && b && z));

  // R10
  catch_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (catch_up && $past(catch_up)) |-> (pos == $past(pos) || pos == $past(pos) + 1'b1));

  // R5
  spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos != pos_r && !hold_r && had_chg) |-> (32'(since) >= req));

endmodule

bind abz_encoder abz_encoder_chk #(.ANGLE_W(ANGLE_W), .CLK_MHZ(CLK_MHZ)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pos      (pos_q),
  .hold     (hold),
  .catch_up (catch_q),
  .spc      (cfg_spc_i),
  .a        (qa_o),
  .b        (qb_o),
  .z        (qz_o)
);

// File: tb/abz_encoder_test.sv
module abz_encoder_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 12;

  logic        clk, rst_n;
  logic [11:0] angle;
  logic        vld, rev, cstart;
  logic [1:0]  spc;
  logic [7:0]  zoff;
  logic        qa, qb, qz;

  abz_encoder #(.CLK_MHZ(8)) uut (
    .clk               (clk),
    .rst_n             (rst_n),
    .angle_i           (angle),
    .angle_vld_i       (vld),
    .cfg_rev_i         (rev),
    .cfg_spc_i         (spc),
    .cfg_count_start_i (cstart),
    .cfg_zoff_i        (zoff),
    .qa_o              (qa),
    .qb_o              (qb),
    .qz_o              (qz)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int tests, fails;

  // {angle, expected position}, spacing one clock, counting start-up
  localparam logic [23:0] VEC [NVEC] = '{
    {12'd100,  12'd100},   // R10 catch-up from zero
    {12'd300,  12'd300},   // R3
    {12'd290,  12'd300},   // R4 inside deadband
    {12'd284,  12'd300},   // R4 edge of deadband
    {12'd283,  12'd299},   // R4 one step down
    {12'd250,  12'd266},   // R4
    {12'd260,  12'd266},   // R4
    {12'd266,  12'd266},   // R4
    {12'd267,  12'd267},   // R3 first step back up
    {12'd4090, 12'd10},    // R4 short path across wrap
    {12'd5,    12'd10},    // R4
    {12'd4000, 12'd4016}   // R4 position wraps below zero
  };
  localparam int VTAG [NVEC] = '{10, 3, 4, 4, 4, 4, 4, 4, 3, 4, 4, 4};

  // Bench-side quadrature decoder
  logic        trk, zchk;
  logic [11:0] mcnt;
  logic [1:0]  prev_idx;
  int          cyc, last_edge, min_gap, max_gap, edges, downs, bad_step, bad_z;
  bit          have_edge;

  function automatic logic [1:0] ab2idx(input logic a, input logic b);
    return {a, a ^ b};
  endfunction

  always @(negedge clk) begin
    logic [1:0] nidx, d;
    cyc++;
    if (trk) begin
      nidx = ab2idx(qa, qb);
      d    = nidx - prev_idx;
      if (d == 2'd2) bad_step++;
      if (d == 2'd1 || d == 2'd3) begin
        if (d == 2'd1) mcnt = mcnt + 1'b1;
        else begin mcnt = mcnt - 1'b1; downs++; end
        if (have_edge) begin
          if (cyc - last_edge < min_gap) min_gap = cyc - last_edge;
          if (cyc - last_edge > max_gap) max_gap = cyc - last_edge;
        end
        have_edge = 1'b1;
        last_edge = cyc;
        edges++;
      end
      prev_idx = nidx;
      if (zchk && (qz != (mcnt == {zoff, 4'd2}))) bad_z++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input bit cs, input logic [1:0] sp, input bit rv, input logic [7:0] zo);
    @(negedge clk);
    trk = 1'b0; zchk = 1'b0;
    rst_n = 1'b0; vld = 1'b0; angle = '0;
    cstart = cs; spc = sp; rev = rv; zoff = zo;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mcnt = '0; prev_idx = ab2idx(qa, qb);
    edges = 0; downs = 0; bad_step = 0; bad_z = 0;
    have_edge = 1'b0; min_gap = 1 << 30; max_gap = 0;
    trk = cs;
  endtask

  task automatic pulse_valid(input logic [11:0] ang);
    angle = ang; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    finish_run();
  end

  localparam int GAPS [4] = '{4, 1, 64, 16};

  initial begin
    tests = 0; fails = 0; cyc = 0;
    trk = 0; zchk = 0; rst_n = 1'b0; vld = 0; angle = '0;
    rev = 0; spc = 2'b01; cstart = 0; zoff = 8'd77;

    // Hold start-up
    do_reset(1'b0, 2'b01, 1'b0, 8'd77);
    angle = 12'd500;
    repeat (5) @(negedge clk);
    check({qa, qb, qz} == 3'b111, "R1 hold reset", {qa, qb, qz}, 7);
    check({qa, qb, qz} == 3'b111, "R9 hold before valid", {qa, qb, qz}, 7);
    pulse_valid(12'd1234);
    // one clock after the valid edge: position 1234 (mod 4 = 2), index 77*16+2
    angle = 12'd1234;
    check({qa, qb} == 2'b11, "R9 jump to target", {qa, qb}, 3);
    check(qz == 1'b1, "R8 index at offset", qz, 1);
    angle = 12'd1240;
    repeat (20) @(negedge clk);
    check({qa, qb, qz} == 3'b000, "R3 hold mode tracking", {qa, qb, qz}, 0);

    // Counting start-up: idle before valid
    do_reset(1'b1, 2'b01, 1'b0, 8'd3);
    zchk = 1'b1;
    check({qa, qb, qz} == 3'b000, "R1 count reset", {qa, qb, qz}, 0);
    angle = 12'd100;
    repeat (10) @(negedge clk);
    check(edges == 0, "R1 no edge before valid", edges, 0);

    // Vector walk
    for (int i = 0; i < NVEC; i++) begin
      if (i == 0) pulse_valid(VEC[i][23:12]);
      else        angle = VEC[i][23:12];
      repeat (500) @(negedge clk);
      tests++;
      if (mcnt != VEC[i][11:0]) begin
        fails++;
        $display("FAIL R%0d vector %0d: got %0d expected %0d", VTAG[i], i, mcnt, VEC[i][11:0]);
      end
    end
    check(bad_step == 0, "R2 single toggles", bad_step, 0);
    check(bad_z == 0, "R8 index placement", bad_z, 0);

    // R10: target beyond half a turn is reached counting up
    do_reset(1'b1, 2'b01, 1'b0, 8'd0);
    pulse_valid(12'd3000);
    repeat (3100) @(negedge clk);
    check(mcnt == 12'd3000, "R10 position", mcnt, 3000);
    check(downs == 0, "R10 no down steps", downs, 0);

    // R5 / R6: each spacing code, 40-step catch-up
    for (int c = 0; c < 4; c++) begin
      do_reset(1'b1, 2'(c), 1'b0, 8'd0);
      pulse_valid(12'd40);
      repeat (40 * GAPS[c] + 50) @(negedge clk);
      check(min_gap == GAPS[c], "R5 minimum gap", min_gap, GAPS[c]);
      check(max_gap == GAPS[c], "R6 queued gap", max_gap, GAPS[c]);
      check(edges == 40, "R6 edge count", edges, 40);
    end

    // R7: inverted sense
    do_reset(1'b1, 2'b01, 1'b1, 8'd0);
    pulse_valid(12'd100);
    repeat (4100) @(negedge clk);
    check(mcnt == 12'd3996, "R7 inverted target", mcnt, 3996);
    angle = 12'd110;
    repeat (100) @(negedge clk);
    check(mcnt == 12'd3996, "R7 inverted deadband", mcnt, 3996);
    angle = 12'd120;
    repeat (100) @(negedge clk);
    check(mcnt == 12'd3992, "R7 inverted down", mcnt, 3992);

    finish_run();
  end

endmodule